// File: doc/BRIEF.md
# Self-Checking Self-Repairing Ripple Adder

This block adds two N-bit operands and a carry-in through a chain of single-bit cells. Each cell produces its sum and carry twice. The primary path can be corrupted on purpose through fault-injection controls. The check path recomputes the same bits from the same inputs and is never touched by injection. For each cell, one comparator judges the carry and a second comparator judges the sum. When a comparator disagrees, it raises that cell's flag. The cell then corrects the output by passing the inverted primary bit instead of the primary bit. The repaired carry of each cell drives the next cell, so a corrupted carry never travels down the chain.

The operands, carry-in and injection controls enter together as one transaction on a valid/ready input. The repaired result and the flags leave as one transaction on a valid/ready output. With the output stage enabled (the default), a single register holds the result. The input is ready when that register is empty or is being drained in the same cycle. While out_valid is high and out_ready is low, the held result stays frozen and no new transaction is accepted. With the stage disabled, the result passes through combinationally, out_valid follows in_valid, and in_ready follows out_ready. Reset is synchronous and active high.

Top module: `ssr_ripple_adder`

## Requirements
- R1: For every operand pair and every combination of injected faults in any cells, sum_out equals the low N bits of op_a + op_b + carry_in.
- R2: For every operand pair and every injection, carry_out equals bit N of op_a + op_b + carry_in.
- R3: Bit i of flt_carry is 1 exactly when the injection on cell i's carry forces a value that differs from that cell's true carry.
- R4: Bit i of flt_sum is 1 exactly when the injection on cell i's sum forces a value that differs from that cell's true sum bit.
- R5: fault_any is 1 exactly when any bit of flt_carry or flt_sum is 1.
- R6: Cell i's injection mode sits in bits [2i+1:2i] of inj_sum_mode (sum) and inj_carry_mode (carry). The codes are 00 none, 01 force 0, 10 force 1 and 11 invert.
- R7: In the cycle after reset, out_valid is 0.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1, every output stays stable in the next cycle, and in_ready is 0.
- R9: A transfer takes place when in_valid and in_ready are both high. Its result appears with out_valid high after the next rising edge.
- R10: When both outputs of the same cell are faulted in one transaction, both of its flags rise. The sum and the carry are both repaired, and the downstream cells still produce the true result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input transaction valid |
| in_ready | output | 1 | Block can accept an input transaction |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into cell 0 |
| inj_sum_mode | input | 2N | Sum-path injection mode for each cell |
| inj_carry_mode | input | 2N | Carry-path injection mode for each cell |
| out_valid | output | 1 | Output transaction valid |
| out_ready | input | 1 | Downstream accepts the output |
| sum_out | output | N | Repaired sum |
| carry_out | output | 1 | Repaired carry out of the last cell |
| flt_sum | output | N | Sum-fault flag for each cell |
| flt_carry | output | N | Carry-fault flag for each cell |
| fault_any | output | 1 | OR of all flags |

## Verification
Carry repair and sum repair can fall in the same cycle within one cell. A repaired carry can also feed a downstream cell whose own outputs are being repaired in that same transaction. The bench provokes this by injecting faults into both outputs of the same cells, including invert mode on every cell at once. Random mixes of all four modes across all cells add further cases. Each transaction is judged against a bench model. The model walks the true carry chain, applies each injection code, expects a flag wherever the forced value differs from the true bit, and expects the true sum and carry-out.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    INJ_NONE = 2'b00,
    INJ_SA0  = 2'b01,
    INJ_SA1  = 2'b10,
    INJ_FLIP = 2'b11
  } inj_mode_e;

  function automatic logic inj_apply(input inj_mode_e mode, input logic v);
    unique case (mode)
      INJ_NONE: inj_apply = v;
      INJ_SA0:  inj_apply = 1'b0;
      INJ_SA1:  inj_apply = 1'b1;
      default:  inj_apply = ~v;
    endcase
  endfunction

endpackage

// File: rtl/ssr_fault_inj.sv
module ssr_fault_inj
  import ssr_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       bit_in,
  output logic       bit_out
);
  inj_mode_e mode_e;
  always_comb begin
    mode_e  = inj_mode_e'(mode);
    bit_out = inj_apply(mode_e, bit_in);
  end
endmodule

// File: rtl/ssr_bit_cell.sv
module ssr_bit_cell (
  input  logic       a,
  input  logic       b,
  input  logic       ci,
  input  logic [1:0] inj_s,
  input  logic [1:0] inj_c,
  output logic       s_fix,
  output logic       c_fix,
  output logic       flag_s,
  output logic       flag_c
);
  // primary path, exposed to injection
  logic s_raw, c_raw, s_pri, c_pri;
  always_comb begin
    s_raw = a ^ b ^ ci;
    c_raw = (a & b) | (ci & (a ^ b));
  end

  ssr_fault_inj u_inj_s (.mode(inj_s), .bit_in(s_raw), .bit_out(s_pri));
  ssr_fault_inj u_inj_c (.mode(inj_c), .bit_in(c_raw), .bit_out(c_pri));

  // independent check path: arithmetic form, never injected
  logic [1:0] chk;
  always_comb chk = {1'b0, a} + {1'b0, b} + {1'b0, ci};

  // comparators and repair multiplexers
  always_comb begin
    flag_s = (s_pri != chk[0]);
    flag_c = (c_pri != chk[1]);
    s_fix  = flag_s ? ~s_pri : s_pri;
    c_fix  = flag_c ? ~c_pri : c_pri;
  end
endmodule

// File: rtl/ssr_out_stage.sv
module ssr_out_stage #(
  parameter int W   = 8,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;
      always_comb in_ready = !vld_q || out_ready;
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= in_data;
        end
      end
      always_comb begin
        out_valid = vld_q;
        out_data  = dat_q;
      end
    end else begin : g_pass
      always_comb begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
      logic unused_ok;
      always_comb unused_ok = clk ^ rst;
    end
  endgenerate
endmodule

// File: rtl/ssr_ripple_adder.sv
module ssr_ripple_adder #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  input  logic           carry_in,
  input  logic [2*N-1:0] inj_sum_mode,
  input  logic [2*N-1:0] inj_carry_mode,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N-1:0]   sum_out,
  output logic           carry_out,
  output logic [N-1:0]   flt_sum,
  output logic [N-1:0]   flt_carry,
  output logic           fault_any
);
  localparam int PW = 3 * N + 2;

  logic [N:0]   chain;
  logic [N-1:0] s_fix, f_s, f_c;
  logic         any_c;

  assign chain[0] = carry_in;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_cell
      ssr_bit_cell u_cell (
        .a      (op_a[i]),
        .b      (op_b[i]),
        .ci     (chain[i]),
        .inj_s  (inj_sum_mode[2*i+1:2*i]),
        .inj_c  (inj_carry_mode[2*i+1:2*i]),
        .s_fix  (s_fix[i]),
        .c_fix  (chain[i+1]),
        .flag_s (f_s[i]),
        .flag_c (f_c[i])
      );
    end
  endgenerate

  always_comb any_c = |{f_s, f_c};

  logic [PW-1:0] pk_in, pk_out;
  always_comb pk_in = {any_c, f_c, f_s, chain[N], s_fix};

  ssr_out_stage #(.W(PW), .REG(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pk_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pk_out)
  );

  always_comb {fault_any, flt_carry, flt_sum, carry_out, sum_out} = pk_out;
endmodule

// File: rtl/ssr_ripple_adder_chk.sv
module ssr_ripple_adder_chk #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic         carry_in,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] sum_out,
  input logic         carry_out,
  input logic [N-1:0] flt_sum,
  input logic [N-1:0] flt_carry,
  input logic         fault_any
);
  logic [N:0] ref_sum;
  always_comb ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in};

  generate
    if (REG_OUT) begin : g_reg
      AST_SUM_TRUE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (sum_out == $past(ref_sum[N-1:0]))); // R1
      AST_CARRY_TRUE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (carry_out == $past(ref_sum[N]))); // R2
      AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R9
      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(sum_out) && $stable(carry_out)
          && $stable(flt_sum) && $stable(flt_carry) && $stable(fault_any))); // R8
      AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R8
      AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> !out_valid); // R7
    end else begin : g_comb
      AST_SUM_TRUE: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ({carry_out, sum_out} == ref_sum)); // R1
    end
  endgenerate

  AST_FLAG_OR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fault_any == |{flt_sum, flt_carry})); // R5
endmodule

bind ssr_ripple_adder ssr_ripple_adder_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .out_valid(out_valid),
  .out_ready(out_ready), .sum_out(sum_out), .carry_out(carry_out),
  .flt_sum(flt_sum), .flt_carry(flt_carry), .fault_any(fault_any)
);

// File: tb/ssr_ripple_adder_tb.sv
module ssr_ripple_adder_tb;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [N-1:0]   op_a = '0;
  logic [N-1:0]   op_b = '0;
  logic           carry_in = 1'b0;
  logic [2*N-1:0] inj_sum_mode = '0;
  logic [2*N-1:0] inj_carry_mode = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [N-1:0]   sum_out;
  logic           carry_out;
  logic [N-1:0]   flt_sum;
  logic [N-1:0]   flt_carry;
  logic           fault_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssr_ripple_adder #(.N(N), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .inj_sum_mode(inj_sum_mode), .inj_carry_mode(inj_carry_mode),
    .out_valid(out_valid), .out_ready(out_ready), .sum_out(sum_out),
    .carry_out(carry_out), .flt_sum(flt_sum), .flt_carry(flt_carry),
    .fault_any(fault_any)
  );

  // R6 encoding: 00 none, 01 force 0, 10 force 1, 11 invert
  function automatic logic apply_mode(input logic [1:0] m, input logic v);
    case (m)
      2'b00:   return v;
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return ~v;
    endcase
  endfunction

  function automatic logic [3*N+1:0] model(input logic [N-1:0] a, input logic [N-1:0] b,
                                           input logic ci, input logic [2*N-1:0] ms,
                                           input logic [2*N-1:0] mc);
    logic [N-1:0] s, fs, fc;
    logic c, ts, tc;
    c = ci;
    for (int k = 0; k < N; k++) begin
      ts = a[k] ^ b[k] ^ c;
      tc = (a[k] & b[k]) | (c & (a[k] ^ b[k]));
      s[k]  = ts;
      fs[k] = apply_mode(ms[2*k+:2], ts) != ts;
      fc[k] = apply_mode(mc[2*k+:2], tc) != tc;
      c = tc;
    end
    return {|{fs, fc}, fc, fs, c, s};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input logic [3*N+1:0] e);
    logic [N-1:0] es, efs, efc;
    logic eco, eany;
    {eany, efc, efs, eco, es} = e;
    check(out_valid === 1'b1, "R9", 64'(out_valid), 64'd1);
    check(sum_out === es, "R1", 64'(sum_out), 64'(es));
    check(carry_out === eco, "R2", 64'(carry_out), 64'(eco));
    check(flt_carry === efc, "R3", 64'(flt_carry), 64'(efc));
    check(flt_sum === efs, "R4", 64'(flt_sum), 64'(efs));
    check(fault_any === eany, "R5", 64'(fault_any), 64'(eany));
  endtask

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input logic ci,
                        input logic [2*N-1:0] ms, input logic [2*N-1:0] mc);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci;
    inj_sum_mode = ms; inj_carry_mode = mc;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(model(a, b, ci, ms, mc));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3*N+1:0] exp_a, exp_b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: idle after reset
    check(out_valid === 1'b0, "R7", 64'(out_valid), 64'd0);
    check(in_ready === 1'b1, "R8", 64'(in_ready), 64'd1);

    // directed corners
    run_op(8'hFF, 8'h01, 1'b0, '0, '0);
    run_op(8'hFF, 8'hFF, 1'b1, '0, '0);
    run_op(8'h00, 8'h00, 1'b0, '0, '0);
    // R10: every cell, both outputs inverted at once
    run_op(8'hA5, 8'h5B, 1'b1, {N{2'b11}}, {N{2'b11}});
    run_op(8'hFF, 8'h00, 1'b1, {N{2'b11}}, {N{2'b11}});
    // R3 R4: stuck-at faults that match the true value give no flag
    run_op(8'h00, 8'h00, 1'b0, {N{2'b01}}, {N{2'b01}});
    run_op(8'hFF, 8'hFF, 1'b1, {N{2'b10}}, {N{2'b10}});
    run_op(8'hFF, 8'hFF, 1'b1, {N{2'b01}}, {N{2'b01}});
    run_op(8'h00, 8'h00, 1'b0, {N{2'b10}}, {N{2'b10}});

    // R8: back-pressure hold, then drain with a new transfer
    @(negedge clk);
    op_a = 8'h3C; op_b = 8'h4D; carry_in = 1'b0;
    inj_sum_mode = {N{2'b11}}; inj_carry_mode = '0;
    exp_a = model(8'h3C, 8'h4D, 1'b0, {N{2'b11}}, '0);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check_out(exp_a);
    op_a = 8'h81; op_b = 8'h7F; carry_in = 1'b1;
    inj_sum_mode = '0; inj_carry_mode = {N{2'b10}};
    exp_b = model(8'h81, 8'h7F, 1'b1, '0, {N{2'b10}});
    check(in_ready === 1'b0, "R8", 64'(in_ready), 64'd0);
    repeat (3) @(negedge clk);
    check_out(exp_a);  // R8 held unchanged
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(exp_b);
    @(negedge clk);
    check(out_valid === 1'b0, "R9", 64'(out_valid), 64'd0);

    // random mixes of operands and fault modes
    for (int n = 0; n < 400; n++) begin
      run_op(N'($urandom), N'($urandom), 1'($urandom),
             (2*N)'($urandom), (2*N)'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule